// File: doc/BRIEF.md
# Per-Core Local Interrupt Concentrator

This block gathers the interrupt sources of one cluster and presents one interrupt line to each core. Three kinds of source are merged. The first is wired level inputs from local peripherals. The second is mailbox words that any bus master raises by writing them. The third is free-running periodic timers that software programs with a period. Each core has its own enable mask for each of the three kinds. Its interrupt line is high whenever any source that its masks enable is active.

All control and status go through a word-addressed register port. The address carries a 5-bit function code in bits [9:5] and a 5-bit index in bits [4:0]. For timer and mailbox functions the index picks the source. For mask, status and priority functions it picks the core. Each kind has three mask functions: replace the mask, set bits, and clear bits. A read of the clear function does not touch the mask. It returns that core's enabled active vector for the kind. A priority word reports the lowest-numbered enabled active source of each kind at once, so a handler can choose its service routine with one read.

Top module: `irq_concentrator`

## Requirements
- R1: While reset is low and directly after it, every mask is zero, every mailbox is empty with data zero, every timer is stopped with period and count zero, `irq_out` is all zero and `rsp_valid` is low.
- R2: The word address is `{func[4:0], index[4:0]}`. A read returns its data on `rsp_data` with `rsp_valid` high exactly one cycle after the request. Function codes 7, 11 and 17 to 31 read as zero and ignore writes. So does an index at or above the number of cores, mailboxes or timers that the function addresses.
- R3: Mask functions are 4/5/6 for timers, 8/9/10 for wired inputs and 12/13/14 for mailboxes, each indexed by core. The first code of each group replaces the mask with the written data. The second ORs the data in. The third clears the bits that are set in the data. A read of the first or second code returns the mask. Mask bits at or above the number of sources of that kind always read zero.
- R4: A read of code 6, 10 or 14 returns the active sources of that kind ANDed with the addressed core's mask, and leaves the mask unchanged.
- R5: `irq_out[c]` is high in the same cycle as any wired input, mailbox pending bit or timer pending bit that core c's mask of that kind enables, and low otherwise.
- R6: A write to code 0 at mailbox index i stores the data and sets pending bit i. A read of code 0 at index i returns the stored data and clears pending bit i.
- R7: A write of P to code 1 at timer index t loads both period and count with P. With P = 0 the timer is stopped. Otherwise the count falls by one per cycle. On the cycle edge where the count is 1 the pending bit is set and the count reloads to P, so the bit is set P cycles after the write and every P cycles afterwards. Code 1 reads the period and code 2 reads the count. Writes to code 2 are ignored.
- R8: A write to code 3 at timer index t clears that timer's pending bit, unless the timer expires on the same edge, in which case the bit stays set. A read of code 3 returns the pending bit in bit 0.
- R9: A read of code 15 at core c returns, over the enabled active sources of core c, the lowest timer index in bits [4:0], the lowest wired index in [12:8] and the lowest mailbox index in [20:16]. Bits 24, 25 and 26 flag that the timer, wired and mailbox fields hold a source. A field without a source reads zero.
- R10: A read of code 16 at any index returns the wired input count in bits [7:0], the mailbox count in [15:8] and the timer count in [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address: function code [9:5], index [4:0] |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | DATA_W | Read data |
| hwi_in | input | N_HWI | Level interrupt inputs from local peripherals |
| irq_out | output | N_CORE | One interrupt line per core |

## Verification
Only one register access can happen per cycle, but a timer can expire on the same edge as an acknowledge write to that timer, and the two act on the same pending bit in opposite directions. The bench provokes this with a period-1 timer, which expires on every edge, and with a period-3 timer that is acknowledged over a run of consecutive cycles, so that some of the acknowledges land on an expiry. The outcome is judged at the ports. The reference model keeps the bit set when the two coincide, and the bench compares the per-core interrupt lines and the read-back of code 3 against that model on every clock.

// File: rtl/irq_concentrator_pkg.sv
package irq_concentrator_pkg;

   localparam int FN_W   = 5;
   localparam int IX_W   = 5;
   localparam int ADDR_W = FN_W + IX_W;
   localparam int MAX_SRC = 16;

   // Register function codes; the mask groups are decoded by offset from their base
   typedef enum logic [FN_W-1:0] {
      FN_MBOX = 5'd0,
      FN_PER  = 5'd1,
      FN_VAL  = 5'd2,
      FN_ACK  = 5'd3,
      FN_TMSK = 5'd4,
      FN_TSET = 5'd5,
      FN_TCLR = 5'd6,
      FN_HMSK = 5'd8,
      FN_HSET = 5'd9,
      FN_HCLR = 5'd10,
      FN_MMSK = 5'd12,
      FN_MSET = 5'd13,
      FN_MCLR = 5'd14,
      FN_PRIO = 5'd15,
      FN_CFG  = 5'd16
   } func_e;

   // Source kinds, also the index into the per-kind arrays
   localparam int KIND_HWI = 0;
   localparam int KIND_WTI = 1;
   localparam int KIND_PTI = 2;
   localparam int N_KIND   = 3;

   typedef enum logic [1:0] {
      MOP_LOAD = 2'd0,
      MOP_SET  = 2'd1,
      MOP_CLR  = 2'd2
   } mask_op_e;

   function automatic logic [FN_W-1:0] mask_base(input int kind);
      case (kind)
         KIND_HWI: return FN_HMSK;
         KIND_WTI: return FN_MMSK;
         default:  return FN_TMSK;
      endcase
   endfunction

   // {valid, index} of the lowest set bit; scan from the top so the last hit wins
   function automatic logic [5:0] lowest_set(input logic [MAX_SRC-1:0] v);
      logic [5:0] r;
      r = '0;
      for (int j = MAX_SRC - 1; j >= 0; j--) begin
         if (v[j]) r = {1'b1, 5'(j)};
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
   import irq_concentrator_pkg::*;
#(
   parameter int N_CORE = 4,
   parameter int N_SRC  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [1:0]                       wr_op,
   input  logic [IX_W-1:0]                  wr_core,
   input  logic [MAX_SRC-1:0]               wr_data,
   output logic [N_CORE-1:0][MAX_SRC-1:0]   mask_o
);

   localparam logic [MAX_SRC-1:0] KEEP = MAX_SRC'((32'd1 << N_SRC) - 32'd1);

   if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_src
      $error("irq_mask_bank: N_SRC out of range");
   end

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      logic [MAX_SRC-1:0] m_r;
      logic               hit;

      assign hit = wr_en && (wr_core == IX_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_r <= '0;
         end else if (hit) begin
            case (mask_op_e'(wr_op))
               MOP_LOAD: m_r <= wr_data & KEEP;
               MOP_SET:  m_r <= m_r | (wr_data & KEEP);
               MOP_CLR:  m_r <= m_r & ~wr_data;
               default:  m_r <= m_r;
            endcase
         end
      end

      assign mask_o[c] = m_r;
   end

endmodule

// File: rtl/irq_mailbox_bank.sv
module irq_mailbox_bank
   import irq_concentrator_pkg::*;
#(
   parameter int N_BOX  = 8,
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [IX_W-1:0]    idx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [N_BOX-1:0]   pend_o,
   output logic [DATA_W-1:0]  data_o
);

   logic [N_BOX-1:0][DATA_W-1:0] box_q;

   for (genvar b = 0; b < N_BOX; b++) begin : g_box
      logic [DATA_W-1:0] data_r;
      logic              pend_r;
      logic              hit;

      assign hit = (idx == IX_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_r <= '0;
            pend_r <= 1'b0;
         end else if (wr_en && hit) begin
            data_r <= wdata;
            pend_r <= 1'b1;
         end else if (rd_en && hit) begin
            pend_r <= 1'b0;
         end
      end

      assign box_q[b]  = data_r;
      assign pend_o[b] = pend_r;
   end

   always_comb begin
      data_o = '0;
      for (int b = 0; b < N_BOX; b++) begin
         if (idx == IX_W'(b)) data_o = box_q[b];
      end
   end

endmodule

// File: rtl/irq_timer_bank.sv
module irq_timer_bank
   import irq_concentrator_pkg::*;
#(
   parameter int N_TMR   = 4,
   parameter int TIMER_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               per_we,
   input  logic               ack_we,
   input  logic [IX_W-1:0]    idx,
   input  logic [TIMER_W-1:0] wdata,
   output logic [N_TMR-1:0]   pend_o,
   output logic [TIMER_W-1:0] per_o,
   output logic [TIMER_W-1:0] val_o
);

   logic [N_TMR-1:0][TIMER_W-1:0] per_q;
   logic [N_TMR-1:0][TIMER_W-1:0] val_q;

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      logic [TIMER_W-1:0] per_r;
      logic [TIMER_W-1:0] val_r;
      logic               pend_r;
      logic               hit;
      logic               running;
      logic               expire;

      assign hit     = (idx == IX_W'(t));
      assign running = (per_r != '0);
      assign expire  = running && (val_r <= TIMER_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_r  <= '0;
            val_r  <= '0;
            pend_r <= 1'b0;
         end else begin
            // expiry outranks a same-edge acknowledge
            pend_r <= expire | (pend_r & ~(ack_we & hit));
            if (per_we && hit) begin
               per_r <= wdata;
               val_r <= wdata;
            end else if (running) begin
               val_r <= expire ? per_r : val_r - TIMER_W'(1);
            end
         end
      end

      assign per_q[t]  = per_r;
      assign val_q[t]  = val_r;
      assign pend_o[t] = pend_r;
   end

   always_comb begin
      per_o = '0;
      val_o = '0;
      for (int t = 0; t < N_TMR; t++) begin
         if (idx == IX_W'(t)) begin
            per_o = per_q[t];
            val_o = val_q[t];
         end
      end
   end

endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
   import irq_concentrator_pkg::*;
#(
   parameter int N_CORE  = 4,
   parameter int N_HWI   = 8,
   parameter int N_WTI   = 8,
   parameter int N_PTI   = 4,
   parameter int DATA_W  = 32,
   parameter int TIMER_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [9:0]          req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   input  logic [N_HWI-1:0]    hwi_in,
   output logic [N_CORE-1:0]   irq_out
);

   // ---------------- elaboration checks ----------------
   if (N_CORE < 1 || N_CORE > 32) begin : g_bad_core
      $error("irq_concentrator: N_CORE must be 1..32");
   end
   if (N_HWI < 1 || N_HWI > MAX_SRC || N_WTI < 1 || N_WTI > MAX_SRC ||
       N_PTI < 1 || N_PTI > MAX_SRC) begin : g_bad_src
      $error("irq_concentrator: source counts must be 1..16");
   end
   if (DATA_W < 27) begin : g_bad_data
      $error("irq_concentrator: DATA_W must hold the priority word");
   end
   if (TIMER_W < 1 || TIMER_W > DATA_W) begin : g_bad_timer
      $error("irq_concentrator: TIMER_W must be 1..DATA_W");
   end

   // ---------------- request decode ----------------
   logic [FN_W-1:0] fn;
   logic [IX_W-1:0] idx;
   logic            wr, rd;
   logic            core_ok, wti_ok, pti_ok;

   assign fn      = req_addr[ADDR_W-1:IX_W];
   assign idx     = req_addr[IX_W-1:0];
   assign wr      = req_valid & req_write;
   assign rd      = req_valid & ~req_write;
   assign core_ok = int'(idx) < N_CORE;
   assign wti_ok  = int'(idx) < N_WTI;
   assign pti_ok  = int'(idx) < N_PTI;

   // ---------------- sources ----------------
   logic [N_WTI-1:0]   wti_pend;
   logic [N_PTI-1:0]   pti_pend;
   logic [DATA_W-1:0]  mbox_rd;
   logic [TIMER_W-1:0] tmr_per, tmr_val;

   irq_mailbox_bank #(
      .N_BOX  (N_WTI),
      .DATA_W (DATA_W)
   ) u_mbox (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr && fn == FN_MBOX && wti_ok),
      .rd_en  (rd && fn == FN_MBOX && wti_ok),
      .idx    (idx),
      .wdata  (req_wdata),
      .pend_o (wti_pend),
      .data_o (mbox_rd)
   );

   irq_timer_bank #(
      .N_TMR   (N_PTI),
      .TIMER_W (TIMER_W)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .per_we (wr && fn == FN_PER && pti_ok),
      .ack_we (wr && fn == FN_ACK && pti_ok),
      .idx    (idx),
      .wdata  (req_wdata[TIMER_W-1:0]),
      .pend_o (pti_pend),
      .per_o  (tmr_per),
      .val_o  (tmr_val)
   );

   logic [N_KIND-1:0][MAX_SRC-1:0] act;
   assign act[KIND_HWI] = MAX_SRC'(hwi_in);
   assign act[KIND_WTI] = MAX_SRC'(wti_pend);
   assign act[KIND_PTI] = MAX_SRC'(pti_pend);

   // ---------------- per-kind mask banks ----------------
   logic [N_KIND-1:0][N_CORE-1:0][MAX_SRC-1:0] msk;

   for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      localparam int              NS   = (k == KIND_HWI) ? N_HWI :
                                         (k == KIND_WTI) ? N_WTI : N_PTI;
      localparam logic [FN_W-1:0] BASE = mask_base(k);
      logic       in_grp;
      logic [1:0] op;

      assign in_grp = (fn == BASE) || (fn == BASE + FN_W'(1)) || (fn == BASE + FN_W'(2));
      assign op     = 2'(fn - BASE);

      irq_mask_bank #(
         .N_CORE (N_CORE),
         .N_SRC  (NS)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr && in_grp && core_ok),
         .wr_op   (op),
         .wr_core (idx),
         .wr_data (req_wdata[MAX_SRC-1:0]),
         .mask_o  (msk[k])
      );
   end

   // ---------------- per-core concentration ----------------
   logic [N_CORE-1:0][N_KIND-1:0][MAX_SRC-1:0] live;
   logic [N_CORE-1:0][DATA_W-1:0]              prio;

   for (genvar c = 0; c < N_CORE; c++) begin : g_cpu
      logic [5:0] w_h, w_w, w_p;

      for (genvar k = 0; k < N_KIND; k++) begin : g_live
         assign live[c][k] = act[k] & msk[k][c];
      end

      assign irq_out[c] = |live[c];

      assign w_p = lowest_set(live[c][KIND_PTI]);
      assign w_h = lowest_set(live[c][KIND_HWI]);
      assign w_w = lowest_set(live[c][KIND_WTI]);

      always_comb begin
         prio[c]        = '0;
         prio[c][4:0]   = w_p[4:0];
         prio[c][12:8]  = w_h[4:0];
         prio[c][20:16] = w_w[4:0];
         prio[c][24]    = w_p[5];
         prio[c][25]    = w_h[5];
         prio[c][26]    = w_w[5];
      end
   end

   // ---------------- read path ----------------
   logic [N_KIND-1:0][MAX_SRC-1:0] sel_msk, sel_live;
   logic [DATA_W-1:0]              sel_prio;
   logic                           sel_tpend;
   logic [DATA_W-1:0]              cfg_word;
   logic [DATA_W-1:0]              rd_word;

   always_comb begin
      sel_msk  = '0;
      sel_live = '0;
      sel_prio = '0;
      for (int c = 0; c < N_CORE; c++) begin
         if (idx == IX_W'(c)) begin
            for (int k = 0; k < N_KIND; k++) begin
               sel_msk[k]  = msk[k][c];
               sel_live[k] = live[c][k];
            end
            sel_prio = prio[c];
         end
      end
      sel_tpend = 1'b0;
      for (int t = 0; t < N_PTI; t++) begin
         if (idx == IX_W'(t)) sel_tpend = pti_pend[t];
      end
   end

   always_comb begin
      cfg_word        = '0;
      cfg_word[7:0]   = 8'(N_HWI);
      cfg_word[15:8]  = 8'(N_WTI);
      cfg_word[23:16] = 8'(N_PTI);
   end

   always_comb begin
      rd_word = '0;
      case (fn)
         FN_MBOX: if (wti_ok)  rd_word = mbox_rd;
         FN_PER:  if (pti_ok)  rd_word = DATA_W'(tmr_per);
         FN_VAL:  if (pti_ok)  rd_word = DATA_W'(tmr_val);
         FN_ACK:  if (pti_ok)  rd_word = DATA_W'(sel_tpend);
         FN_TMSK, FN_TSET: if (core_ok) rd_word = DATA_W'(sel_msk[KIND_PTI]);
         FN_TCLR:          if (core_ok) rd_word = DATA_W'(sel_live[KIND_PTI]);
         FN_HMSK, FN_HSET: if (core_ok) rd_word = DATA_W'(sel_msk[KIND_HWI]);
         FN_HCLR:          if (core_ok) rd_word = DATA_W'(sel_live[KIND_HWI]);
         FN_MMSK, FN_MSET: if (core_ok) rd_word = DATA_W'(sel_msk[KIND_WTI]);
         FN_MCLR:          if (core_ok) rd_word = DATA_W'(sel_live[KIND_WTI]);
         FN_PRIO:          if (core_ok) rd_word = sel_prio;
         FN_CFG:  rd_word = cfg_word;
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd;
         rsp_data  <= rd ? rd_word : '0;
      end
   end

endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk #(
   parameter int N_CORE = 4,
   parameter int N_HWI  = 8,
   parameter int N_WTI  = 8,
   parameter int N_PTI  = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [9:0]        req_addr,
   input logic [N_HWI-1:0]  hwi_in,
   input logic [N_WTI-1:0]  wti_pend,
   input logic [N_PTI-1:0]  pti_pend,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic [N_CORE-1:0] irq_out
);

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0 && !rsp_valid));

   p_rsp_only_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   p_read_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   p_unused_code_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write &&
       (req_addr[9:5] == 5'd7 || req_addr[9:5] == 5'd11 || req_addr[9:5] > 5'd16))
      |=> (rsp_data == '0));

   p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> ((|hwi_in) || (|wti_pend) || (|pti_pend)));

   p_mbox_write_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[9:5] == 5'd0 && int'(req_addr[4:0]) < N_WTI)
      |=> (((32'(wti_pend) >> $past(req_addr[4:0])) & 32'd1) == 32'd1));

   p_mbox_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[9:5] == 5'd0 && int'(req_addr[4:0]) < N_WTI)
      |=> (((32'(wti_pend) >> $past(req_addr[4:0])) & 32'd1) == 32'd0));

endmodule

bind irq_concentrator irq_concentrator_chk #(
   .N_CORE (N_CORE),
   .N_HWI  (N_HWI),
   .N_WTI  (N_WTI),
   .N_PTI  (N_PTI),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .hwi_in    (hwi_in),
   .wti_pend  (wti_pend),
   .pti_pend  (pti_pend),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data),
   .irq_out   (irq_out)
);

// File: tb/irq_concentrator_tb.sv
`timescale 1ns/1ps
module irq_concentrator_tb;

   localparam int NC = 4, NH = 8, NW = 8, NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic [NH-1:0] hwi_in = '0;
   logic [NC-1:0] irq_out;

   always #10 clk = ~clk;   // 50 MHz

   irq_concentrator #(.N_CORE(NC), .N_HWI(NH), .N_WTI(NW), .N_PTI(NP),
                      .DATA_W(32), .TIMER_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .hwi_in(hwi_in), .irq_out(irq_out));

   int vectors = 0, miscompares = 0;

   // ---------------- reference model state ----------------
   logic [15:0]   mmask [3][NC];
   logic [31:0]   mbox [NW];
   logic [NW-1:0] mpend = '0;
   logic [31:0]   tper [NP];
   logic [31:0]   tval [NP];
   logic [NP-1:0] tpend = '0;
   logic [NH-1:0] hwi = '0;
   logic          exp_rv = 1'b0;
   logic [31:0]   exp_rd = '0;
   int            last_fn = 0;

   function automatic logic [9:0] A(int f, int i);
      return {5'(f), 5'(i)};
   endfunction

   function automatic logic [15:0] active(int k);
      if (k == 0) return 16'(hwi);
      if (k == 1) return 16'(mpend);
      return 16'(tpend);
   endfunction

   function automatic int kind_of(int f);
      if (f >= 4 && f <= 6) return 2;
      if (f >= 8 && f <= 10) return 0;
      if (f >= 12 && f <= 14) return 1;
      return -1;
   endfunction

   function automatic int src_count(int k);
      return (k == 0) ? NH : (k == 1) ? NW : NP;
   endfunction

   function automatic logic [5:0] first_of(logic [15:0] v);
      for (int j = 0; j < 16; j++) if (v[j]) return {1'b1, 5'(j)};
      return 6'd0;
   endfunction

   function automatic logic [31:0] model_read(int f, int i);
      int k;
      logic [5:0] a, b, c;
      k = kind_of(f);
      if (f == 0) return (i < NW) ? mbox[i] : 32'd0;
      if (f == 1) return (i < NP) ? tper[i] : 32'd0;
      if (f == 2) return (i < NP) ? tval[i] : 32'd0;
      if (f == 3) return (i < NP) ? 32'(tpend[i]) : 32'd0;
      if (k >= 0) begin
         if (i >= NC) return 32'd0;
         if (f % 4 == 2) return 32'(active(k) & mmask[k][i]);
         return 32'(mmask[k][i]);
      end
      if (f == 15) begin
         if (i >= NC) return 32'd0;
         a = first_of(active(2) & mmask[2][i]);
         b = first_of(active(0) & mmask[0][i]);
         c = first_of(active(1) & mmask[1][i]);
         return {5'd0, c[5], b[5], a[5], 3'd0, c[4:0], 3'd0, b[4:0], 3'd0, a[4:0]};
      end
      if (f == 16) return (NP << 16) | (NW << 8) | NH;
      return 32'd0;
   endfunction

   // one clock edge of the model, from the pre-edge state
   task automatic model_edge(bit v, bit w, logic [9:0] a, logic [31:0] d);
      int f, i, k;
      logic [15:0] keep;
      logic        fire;
      f = int'(a[9:5]);
      i = int'(a[4:0]);
      exp_rv  = v && !w;
      exp_rd  = (v && !w) ? model_read(f, i) : 32'd0;
      last_fn = f;
      if (v && f == 0 && i < NW) begin
         if (w) begin mbox[i] = d; mpend[i] = 1'b1; end
         else mpend[i] = 1'b0;
      end
      k = kind_of(f);
      if (v && w && k >= 0 && i < NC) begin
         keep = 16'((32'd1 << src_count(k)) - 1);
         case (f % 4)
            0: mmask[k][i] = d[15:0] & keep;
            1: mmask[k][i] = mmask[k][i] | (d[15:0] & keep);
            default: mmask[k][i] = mmask[k][i] & ~d[15:0];
         endcase
      end
      for (int t = 0; t < NP; t++) begin
         fire = (tper[t] != 0) && (tval[t] <= 1);
         if (fire) tpend[t] = 1'b1;
         else if (v && w && f == 3 && i == t) tpend[t] = 1'b0;
         if (v && w && f == 1 && i == t) begin
            tper[t] = d; tval[t] = d;
         end else if (tper[t] != 0) begin
            tval[t] = fire ? tper[t] : tval[t] - 1;
         end
      end
   endtask

   function automatic string tag_of(int f);
      case (f)
         0: return "R6";
         1, 2: return "R7";
         3: return "R8";
         4, 5, 8, 9, 12, 13: return "R3";
         6, 10, 14: return "R4";
         15: return "R9";
         16: return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [NC-1:0] ei;
      for (int c = 0; c < NC; c++)
         ei[c] = |((active(0) & mmask[0][c]) | (active(1) & mmask[1][c]) |
                   (active(2) & mmask[2][c]));
      check("R5 irq_out", 32'(irq_out), 32'(ei));
      check("R2 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
      if (exp_rv) check(tag_of(last_fn), rsp_data, exp_rd);
   endtask

   // drive one cycle at the falling edge, step the model at the rising edge, compare after
   task automatic cyc(bit v, bit w, logic [9:0] a, logic [31:0] d);
      req_valid = v; req_write = w; req_addr = a; req_wdata = d; hwi_in = hwi;
      @(posedge clk);
      model_edge(v, w, a, d);
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
   task automatic rd(logic [9:0] a);                 cyc(1'b1, 1'b0, a, 32'd0); endtask
   task automatic idle(int n); for (int j = 0; j < n; j++) cyc(1'b0, 1'b0, 10'd0, 32'd0); endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] x;
      int f, i;
      for (int k = 0; k < 3; k++) for (int c = 0; c < NC; c++) mmask[k][c] = '0;
      for (int b = 0; b < NW; b++) mbox[b] = '0;
      for (int t = 0; t < NP; t++) begin tper[t] = '0; tval[t] = '0; end

      // R1: held in reset, then quiet afterwards
      repeat (3) @(negedge clk);
      check("R1 irq_out in reset", 32'(irq_out), 32'd0);
      check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      idle(2);
      rd(A(8, 0)); rd(A(0, 2)); rd(A(1, 1)); rd(A(15, 3));

      // R10 and R2: configuration and unused codes
      rd(A(16, 9));
      check("R10 config literal", rsp_data, 32'h0004_0808);
      wr(A(7, 0), 32'hFFFF_FFFF); rd(A(7, 0)); rd(A(11, 1)); rd(A(17, 0)); rd(A(31, 31));
      wr(A(8, 4), 32'hFFFF);  rd(A(8, 4));          // core index out of range
      wr(A(1, 6), 32'd3);     rd(A(1, 6));          // timer index out of range

      // R3: mask replace / set / clear
      wr(A(8, 1), 32'hFFFF); rd(A(8, 1));
      wr(A(10, 1), 32'h00F0); rd(A(9, 1));
      wr(A(9, 1), 32'h0030);  rd(A(8, 1));
      wr(A(12, 2), 32'h0028); wr(A(13, 2), 32'h0001); rd(A(13, 2));

      // R5, R4, R9: wired inputs
      hwi = 8'h24; idle(1);
      rd(A(10, 1)); rd(A(8, 1)); rd(A(15, 1));
      hwi = 8'h80; idle(1); rd(A(15, 1));
      hwi = 8'h00; idle(1);

      // R6: mailboxes, with priority across kinds
      wr(A(0, 5), 32'hCAFE_0005); wr(A(0, 3), 32'hBEEF_0003);
      rd(A(14, 2)); rd(A(15, 2));
      rd(A(0, 3)); rd(A(15, 2)); rd(A(0, 3));
      rd(A(0, 5)); idle(1);

      // R7: timer count, reload and stop
      wr(A(4, 0), 32'h0002);
      wr(A(1, 1), 32'd5);
      for (int j = 0; j < 6; j++) rd(A(2, 1));
      rd(A(1, 1)); rd(A(3, 1));
      wr(A(2, 1), 32'd77); rd(A(2, 1));
      wr(A(3, 1), 32'd0); idle(3);
      wr(A(1, 1), 32'd0); wr(A(3, 1), 32'd0); idle(8); rd(A(3, 1)); rd(A(2, 1));

      // R8: expiry landing on an acknowledge
      wr(A(5, 3), 32'h000F);
      wr(A(1, 0), 32'd1);
      for (int j = 0; j < 4; j++) begin wr(A(3, 0), 32'd0); rd(A(3, 0)); end
      wr(A(1, 0), 32'd0); wr(A(3, 0), 32'd0); rd(A(3, 0));
      wr(A(1, 2), 32'd3);
      for (int j = 0; j < 9; j++) wr(A(3, 2), 32'd0);
      rd(A(3, 2)); rd(A(6, 3));
      wr(A(1, 2), 32'd0); wr(A(3, 2), 32'd0);

      // mixed traffic across every code
      x = 32'h1234_5679;
      for (int n = 0; n < 1500; n++) begin
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         f = int'(x[4:0]);
         if (f > 18) f = 0;
         i = x[9] ? int'(x[8:6]) : int'(x[24:23]);
         if (x[15:13] == 3'd0) hwi = x[23:16];
         if (!x[10]) idle(1);
         else if (x[11]) wr(A(f, i), (f == 1) ? {29'd0, x[30:28]} : x);
         else rd(A(f, i));
      end

      summary();
      $finish;
   end

endmodule